// File: doc/BRIEF.md
# Ones' Complement End-Around Adder

This block adds two WIDTH-bit ones' complement operands and returns a registered result one clock later. The carry leaving the top bit is fed back into bit 0. A mode input turns the adder into a subtractor by inverting the second operand before the add. The same two-stage carry path serves both modes.

Ones' complement has two encodings of zero: all zeros (positive zero) and all ones (negative zero). Adding a value to its own complement produces no carry and leaves all ones. The zero flag is raised for either encoding. An optional normalise input folds negative zero to positive zero at the output. The carry flag reports the raw carry out of the top bit before it is wrapped around. There is no handshake: operands are applied on one clock and the result, carry and zero flags appear after the next rising edge.

Top module: `oc_eac_adder_top`

## Requirements
- R1: While `rst` is high at a rising edge, `res_q`, `carry_q` and `zero_q` become 0 on that edge.
- R2: With `sub_en` = 0, the result is the end-around sum: take the (WIDTH+1)-bit sum of `op_a` and `op_b`, then add its top bit back into its low WIDTH bits (for example 0xFD + 0x05 gives 0x03).
- R3: With `sub_en` = 1, the result is the end-around sum of `op_a` and the bitwise inverse of `op_b` (for example 4 - 9 gives 0xFA).
- R4: In add mode, adding negative zero (all ones) to a non-zero operand x with normalise low returns x unchanged, with the carry flag set.
- R5: With normalise low, operands whose effective sum is all ones (an operand plus its complement, or x - x) give an all-ones result with no carry.
- R6: `zero_q` is 1 exactly when `res_q` is all zeros or all ones.
- R7: With `norm_en` = 1, an all-ones result is output as all zeros with `zero_q` still 1. All other results and the carry flag are unchanged by `norm_en`.
- R8: `carry_q` is the carry out of the top bit of the first addition, before the wrap-around.
- R9: Result and flags for operands applied before a rising edge appear on that edge. A new operand pair may be applied on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| sub_en | input | 1 | 0 = add, 1 = subtract (invert `op_b`) |
| norm_en | input | 1 | 1 = fold an all-ones result to all zeros |
| res_q | output | WIDTH | Registered ones' complement result |
| carry_q | output | 1 | Registered raw carry out of the top bit |
| zero_q | output | 1 | Registered zero flag, either encoding |

## Verification
The assertions assume that `op_a`, `op_b`, `sub_en` and `norm_en` hold known values at every rising edge after reset. Properties that look back through `$past` are also gated until one clock has passed since reset. The stimulus meets both assumptions: every input is driven to a defined value from time zero and is changed only on the falling edge. The stimulus combines directed corner operands (both zero encodings, self-cancelling pairs, top-bit carries, normalise on and off) with back-to-back random pairs in both modes.

// File: rtl/oc_pkg.sv
package oc_pkg;

    // Operation selected for the second operand.
    typedef enum logic {
        OPM_ADD = 1'b0,
        OPM_SUB = 1'b1
    } opmode_e;

    // Flags carried alongside the registered result.
    typedef struct packed {
        logic carry;
        logic zero;
    } oc_flags_t;

    // Select the adder build style.
    localparam int unsigned STYLE_BEHAV  = 0;
    localparam int unsigned STYLE_RIPPLE = 1;

    function automatic opmode_e mode_of(input logic sub_bit);
        return sub_bit ? OPM_SUB : OPM_ADD;
    endfunction

    function automatic oc_flags_t make_flags(input logic c, input logic z);
        oc_flags_t f;
        f.carry = c;
        f.zero  = z;
        return f;
    endfunction

endpackage

// File: rtl/oc_operand_prep.sv
module oc_operand_prep
    import oc_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] b_in,
    input  opmode_e          mode,
    output logic [WIDTH-1:0] b_eff
);

    always_comb begin
        unique case (mode)
            OPM_SUB: b_eff = ~b_in;
            default: b_eff = b_in;
        endcase
    end

endmodule

// File: rtl/oc_eac_core.sv
module oc_eac_core
    import oc_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned STYLE = STYLE_RIPPLE
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] sum,
    output logic             raw_carry
);

    localparam int unsigned TOP = WIDTH - 1;

    generate
        if (STYLE == STYLE_RIPPLE) begin : g_ripple
            logic [WIDTH:0]   c_add;
            logic [WIDTH-1:0] raw;
            logic [WIDTH-1:0] c_inc;

            assign c_add[0] = 1'b0;
            for (genvar i = 0; i < WIDTH; i++) begin : g_add
                assign raw[i]     = a[i] ^ b[i] ^ c_add[i];
                assign c_add[i+1] = (a[i] & b[i]) | (c_add[i] & (a[i] ^ b[i]));
            end

            // Second pass: increment the raw sum by the wrapped carry.
            assign c_inc[0] = c_add[WIDTH];
            for (genvar j = 0; j < WIDTH; j++) begin : g_inc
                assign sum[j] = raw[j] ^ c_inc[j];
                if (j < TOP) begin : g_chain
                    assign c_inc[j+1] = raw[j] & c_inc[j];
                end
            end

            assign raw_carry = c_add[WIDTH];
        end else begin : g_behav
            logic [WIDTH:0] full;

            assign full      = {1'b0, a} + {1'b0, b};
            assign raw_carry = full[WIDTH];
            assign sum       = full[WIDTH-1:0] + {{TOP{1'b0}}, full[WIDTH]};
        end
    endgenerate

endmodule

// File: rtl/oc_zero_norm.sv
module oc_zero_norm #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] sum_in,
    input  logic             norm,
    output logic [WIDTH-1:0] sum_out,
    output logic             is_zero
);

    logic pos_zero;
    logic neg_zero;

    assign pos_zero = ~|sum_in;
    assign neg_zero = &sum_in;
    assign is_zero  = pos_zero | neg_zero;

    always_comb begin
        if (norm && neg_zero) begin
            sum_out = '0;
        end else begin
            sum_out = sum_in;
        end
    end

endmodule

// File: rtl/oc_eac_adder_top.sv
module oc_eac_adder_top
    import oc_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned STYLE = STYLE_RIPPLE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             sub_en,
    input  logic             norm_en,
    output logic [WIDTH-1:0] res_q,
    output logic             carry_q,
    output logic             zero_q
);

    opmode_e          mode;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] sum_wrapped;
    logic             carry_raw;
    logic [WIDTH-1:0] sum_final;
    logic             zero_raw;
    oc_flags_t        flags_d;
    oc_flags_t        flags_q;

    assign mode = mode_of(sub_en);

    oc_operand_prep #(.WIDTH(WIDTH)) u_prep (
        .b_in  (op_b),
        .mode  (mode),
        .b_eff (b_eff)
    );

    oc_eac_core #(.WIDTH(WIDTH), .STYLE(STYLE)) u_core (
        .a         (op_a),
        .b         (b_eff),
        .sum       (sum_wrapped),
        .raw_carry (carry_raw)
    );

    oc_zero_norm #(.WIDTH(WIDTH)) u_norm (
        .sum_in  (sum_wrapped),
        .norm    (norm_en),
        .sum_out (sum_final),
        .is_zero (zero_raw)
    );

    assign flags_d = make_flags(carry_raw, zero_raw);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            flags_q <= '0;
        end else begin
            res_q   <= sum_final;
            flags_q <= flags_d;
        end
    end

    assign carry_q = flags_q.carry;
    assign zero_q  = flags_q.zero;

endmodule

// File: rtl/oc_eac_chk.sv
module oc_eac_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             sub_en,
    input logic             norm_en,
    input logic [WIDTH-1:0] res_q,
    input logic             carry_q,
    input logic             zero_q
);

    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    AST_ZERO_FLAG_MATCH: assert property (@(posedge clk) disable iff (rst)
        zero_q |-> (res_q == '0 || res_q == '1)); // R6

    AST_NEGZERO_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(!sub_en && !norm_en && op_b == '1 && op_a != '0))
        |-> (res_q == $past(op_a) && carry_q)); // R4

    AST_SELF_CANCEL_NEG: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(!norm_en) &&
         (($past(!sub_en) && ($past(op_a) ^ $past(op_b)) == '1) ||
          ($past(sub_en) && $past(op_a) == $past(op_b))))
        |-> (res_q == '1 && !carry_q)); // R5

    AST_NORM_NO_NEGZERO: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(norm_en)) |-> (res_q != '1)); // R7

    AST_MSB_PAIR_CARRY: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(!sub_en && op_a[WIDTH-1] && op_b[WIDTH-1]))
        |-> carry_q); // R8

    AST_SUB_SELF_ZERO: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(sub_en && op_a == op_b)) |-> zero_q); // R3

endmodule

bind oc_eac_adder_top oc_eac_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .op_a    (op_a),
    .op_b    (op_b),
    .sub_en  (sub_en),
    .norm_en (norm_en),
    .res_q   (res_q),
    .carry_q (carry_q),
    .zero_q  (zero_q)
);

// File: tb/sim_oc_eac_adder_top.sv
`timescale 1ns/1ps
module sim_oc_eac_adder_top;

    localparam int W    = 8;
    localparam int MASK = (1 << W) - 1;

    typedef struct {
        int    res;
        bit    c;
        bit    z;
        string tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] op_a = '1;
    logic [W-1:0] op_b = '1;
    logic         sub_en = 1'b0;
    logic         norm_en = 1'b0;
    logic [W-1:0] res_q;
    logic         carry_q;
    logic         zero_q;

    int   n_checks = 0;
    int   n_errors = 0;
    exp_t pend[$];

    always #2.5 clk = ~clk;

    oc_eac_adder_top #(.WIDTH(W)) u0 (
        .clk     (clk),
        .rst     (rst),
        .op_a    (op_a),
        .op_b    (op_b),
        .sub_en  (sub_en),
        .norm_en (norm_en),
        .res_q   (res_q),
        .carry_q (carry_q),
        .zero_q  (zero_q)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic exp_t model(input int a, input int b, input bit sub,
                                   input bit norm, input string tag);
        exp_t e;
        int bb, t, c, s;
        bb = sub ? (~b & MASK) : b;
        t  = a + bb;
        c  = t >> W;
        s  = (t & MASK) + c;
        if (norm && s == MASK) s = 0;
        e.res = s;
        e.c   = bit'(c);
        e.z   = (s == 0) || (s == MASK);
        e.tag = tag;
        return e;
    endfunction

    task automatic compare_pending();
        exp_t e;
        if (pend.size() > 0) begin
            e = pend.pop_front();
            check(int'(res_q) == e.res, e.tag, int'(res_q), e.res);
            check(carry_q == e.c, {e.tag, "/R8 carry"}, int'(carry_q), int'(e.c));
            check(zero_q == e.z, {e.tag, "/R6 zero"}, int'(zero_q), int'(e.z));
        end
    endtask

    // Drive on a falling edge; result of the previous pair is due now.
    task automatic put(input int a, input int b, input bit sub, input bit norm,
                       input string tag);
        @(negedge clk);
        compare_pending();
        op_a    = W'(a);
        op_b    = W'(b);
        sub_en  = sub;
        norm_en = norm;
        pend.push_back(model(a, b, sub, norm, tag));
    endtask

    task automatic flush();
        @(negedge clk);
        compare_pending();
    endtask

    initial begin
        #400000;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset clears outputs even with all-ones operands applied
        check(res_q == '0, "R1 res", int'(res_q), 0);
        check(carry_q == 1'b0, "R1 carry", int'(carry_q), 0);
        check(zero_q == 1'b0, "R1 zero", int'(zero_q), 0);
        rst = 1'b0;

        put(8'h05, 8'h03, 0, 0, "R2 5+3");
        put(8'h7F, 8'h01, 0, 0, "R2 7F+01");
        put(8'hFD, 8'h05, 0, 0, "R2 wrap FD+05");
        put(8'h09, 8'h04, 1, 0, "R3 9-4");
        put(8'h04, 8'h09, 1, 0, "R3 4-9");
        put(8'h42, 8'hFF, 0, 0, "R4 42+negzero");
        put(8'h01, 8'hFF, 0, 0, "R4 01+negzero");
        put(8'h3C, 8'hC3, 0, 0, "R5 x+~x");
        put(8'h55, 8'h55, 1, 0, "R5 x-x");
        put(8'h00, 8'hFF, 0, 0, "R5 0+negzero");
        put(8'hFF, 8'hFF, 0, 0, "R6 negzero+negzero");
        put(8'h00, 8'h00, 0, 0, "R6 0+0");
        put(8'h55, 8'h55, 1, 1, "R7 x-x norm");
        put(8'hFF, 8'hFF, 0, 1, "R7 negzero+negzero norm");
        put(8'h05, 8'h03, 0, 1, "R7 nonzero norm");
        put(8'h80, 8'h80, 0, 0, "R8 msb pair");
        put(8'h80, 8'h7F, 0, 0, "R8 no carry");
        for (int i = 0; i < 3000; i++) begin
            bit s;
            s = 1'($urandom);
            put(int'($urandom & MASK), int'($urandom & MASK), s,
                1'($urandom), s ? "R9 stream R3" : "R9 stream R2");
        end
        flush();

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule